// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block holds two message words inside a memory map that two ports share, the left port and the right port. Each port owns one of the two words. When a port writes the word owned by the other side, the owner's interrupt line goes active. The owner drops its interrupt by reading its own word. The message has no fixed meaning: software on both sides decides what the word says.

Each port brings a chip enable, a read/write select, an address, write data and a hold input. The hold input comes from an external contention arbiter. While hold is active, that port cannot raise the other side's interrupt and cannot clear its own. Either side may read the other side's word at any time, and that read has no side effect. The block stores the two words and drives one registered, active-low interrupt output and one registered read-data bus per port.

Top module: `dmb_mailbox_top`

## Requirements
- R1: The right port's word sits at the all-ones address and the left port's word sits at the all-ones address minus one. When the left port writes the all-ones address with hold low, `r_irq_n` reads 0 after the next clock edge. When the right port writes the all-ones-minus-one address with hold low, `l_irq_n` reads 0 after the next clock edge.
- R2: When a port reads its own word with hold low, its interrupt reads 1 after the next clock edge. This holds only if the other port does not write that word on the same edge.
- R3: When a port reads the other port's word, it gets that word back. The read leaves the other port's interrupt unchanged.
- R4: When a port writes the other port's word with its hold input high, the owner's interrupt does not change and the stored word does not change.
- R5: When a port reads its own word with its hold input high, it still gets the word back, but its interrupt stays active.
- R6: Any 16-bit value written is read back unchanged. Read data is valid on the cycle after the read edge and shows the word as it was before any write on that same edge. On cycles with no read of a mailbox address, read data is 0.
- R7: After reset, both interrupt outputs are 1, both read-data buses are 0 and both stored words are 0.
- R8: An access counts only when the port's enable is 0. A write is taken on an edge where the read/write select is 0, and a read on an edge where it is 1. With enable at 1, nothing changes.
- R9: If the owner reads its word on the same edge that the other port writes it, the set wins and the interrupt stays active.
- R10: If both ports write the same word on the same edge, the other port's data is kept, not the owner's, and the owner's interrupt is raised.
- R11: A port that writes its own word stores the value and leaves its own interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_en_n | input | 1 | Left port enable, active low |
| l_wr_n | input | 1 | Left port select: 0 = write, 1 = read |
| l_addr | input | AW | Left port address |
| l_wdata | input | DW | Left port write data |
| l_hold | input | 1 | Left port arbitration hold, active high |
| l_rdata | output | DW | Left port read data, registered |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_en_n | input | 1 | Right port enable, active low |
| r_wr_n | input | 1 | Right port select: 0 = write, 1 = read |
| r_addr | input | AW | Right port address |
| r_wdata | input | DW | Right port write data |
| r_hold | input | 1 | Right port arbitration hold, active high |
| r_rdata | output | DW | Right port read data, registered |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The tests run single-sided set and clear sequences in both directions. These show that each address is tied to the correct owner and that the access direction is decoded correctly. Reads of the other side's word and reads of a plain address are mixed in between, to tell a side-effect-free read from a clearing one. The tests repeat the same accesses with hold high and with enable high, which shows whether the gating reaches both the flag and the storage. Finally, the tests drive both ports on the same edge (set against clear, and the two sides writing the same word) to expose which priority order the design implements.

// File: rtl/dmb_pkg.sv
package dmb_pkg;
  // Decoded access of one port, already qualified by its enable.
  typedef struct packed {
    logic wr_own;   // write to the word this port owns
    logic wr_peer;  // write to the word the other port owns
    logic rd_own;   // read of own word
    logic rd_peer;  // read of the other port's word
  } acc_t;
endpackage

// File: rtl/dmb_decode.sv
module dmb_decode #(
  parameter int AW   = 10,
  parameter int SIDE = 0
) (
  input  logic          en_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  output dmb_pkg::acc_t acc
);
  localparam logic [AW-1:0] TOP_ADDR  = '1;
  localparam logic [AW-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;
  localparam logic [AW-1:0] OWN_ADDR  = (SIDE != 0) ? TOP_ADDR : NEXT_ADDR;
  localparam logic [AW-1:0] PEER_ADDR = (SIDE != 0) ? NEXT_ADDR : TOP_ADDR;

  logic hit_own, hit_peer;
  assign hit_own  = !en_n && (addr == OWN_ADDR);
  assign hit_peer = !en_n && (addr == PEER_ADDR);

  assign acc.wr_own  = hit_own  && !wr_n;
  assign acc.wr_peer = hit_peer && !wr_n;
  assign acc.rd_own  = hit_own  &&  wr_n;
  assign acc.rd_peer = hit_peer &&  wr_n;
endmodule

// File: rtl/dmb_slot.sv
module dmb_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          peer_wr,
  input  logic          peer_blk,
  input  logic [DW-1:0] peer_data,
  input  logic          own_wr,
  input  logic          own_rd,
  input  logic          own_blk,
  input  logic [DW-1:0] own_data,
  output logic [DW-1:0] word,
  output logic          irq_n
);
  logic          flag_q;
  logic [DW-1:0] word_q;
  logic          set_ev, clr_ev, own_st;

  assign set_ev = peer_wr && !peer_blk;
  assign clr_ev = own_rd  && !own_blk;
  assign own_st = own_wr  && !own_blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      word_q <= '0;
    end else begin
      if (set_ev)      flag_q <= 1'b1;
      else if (clr_ev) flag_q <= 1'b0;
      if (set_ev)      word_q <= peer_data;
      else if (own_st) word_q <= own_data;
    end
  end

  assign word  = word_q;
  assign irq_n = ~flag_q;

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (peer_wr && !peer_blk && own_rd && !own_blk) |=> !irq_n); // R9
  AST_OWN_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (own_wr && !peer_wr) |=> $stable(irq_n)); // R11
  AST_PEER_DATA_KEPT: assert property (@(posedge clk) disable iff (rst)
    (peer_wr && !peer_blk) |=> (word == $past(peer_data))); // R10
endmodule

// File: rtl/dmb_mailbox_top.sv
module dmb_mailbox_top #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          l_en_n,
  input  logic          l_wr_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic          l_hold,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq_n,
  input  logic          r_en_n,
  input  logic          r_wr_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  input  logic          r_hold,
  output logic [DW-1:0] r_rdata,
  output logic          r_irq_n
);
  localparam int NPORT = 2;
  localparam logic [AW-1:0] MB_R = '1;
  localparam logic [AW-1:0] MB_L = MB_R - 1'b1;

  logic [NPORT-1:0] en_n, wr_n, hold, irq_n;
  logic [AW-1:0]    addr  [NPORT];
  logic [DW-1:0]    wdata [NPORT];
  logic [DW-1:0]    word  [NPORT];
  dmb_pkg::acc_t    acc   [NPORT];

  assign en_n  = {r_en_n, l_en_n};
  assign wr_n  = {r_wr_n, l_wr_n};
  assign hold  = {r_hold, l_hold};
  assign addr[0]  = l_addr;
  assign addr[1]  = r_addr;
  assign wdata[0] = l_wdata;
  assign wdata[1] = r_wdata;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [DW-1:0] rd_q;

    dmb_decode #(.AW(AW), .SIDE(p)) u_dec (
      .en_n (en_n[p]),
      .wr_n (wr_n[p]),
      .addr (addr[p]),
      .acc  (acc[p])
    );

    always_ff @(posedge clk) begin
      if (rst)                 rd_q <= '0;
      else if (acc[p].rd_own)  rd_q <= word[p];
      else if (acc[p].rd_peer) rd_q <= word[NPORT-1-p];
      else                     rd_q <= '0;
    end

    dmb_slot #(.DW(DW)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .peer_wr   (acc[NPORT-1-p].wr_peer),
      .peer_blk  (hold[NPORT-1-p]),
      .peer_data (wdata[NPORT-1-p]),
      .own_wr    (acc[p].wr_own),
      .own_rd    (acc[p].rd_own),
      .own_blk   (hold[p]),
      .own_data  (wdata[p]),
      .word      (word[p]),
      .irq_n     (irq_n[p])
    );
  end

  assign l_rdata = g_port[0].rd_q;
  assign r_rdata = g_port[1].rd_q;
  assign l_irq_n = irq_n[0];
  assign r_irq_n = irq_n[1];

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (l_irq_n && r_irq_n && l_rdata == '0 && r_rdata == '0)); // R7
  AST_L_RAISES_R: assert property (@(posedge clk) disable iff (rst)
    (!l_en_n && !l_wr_n && l_addr == MB_R && !l_hold) |=> !r_irq_n); // R1
  AST_R_RAISES_L: assert property (@(posedge clk) disable iff (rst)
    (!r_en_n && !r_wr_n && r_addr == MB_L && !r_hold) |=> !l_irq_n); // R1
  AST_L_OWN_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!l_en_n && l_wr_n && l_addr == MB_L && !l_hold &&
     !(!r_en_n && !r_wr_n && r_addr == MB_L)) |=> l_irq_n); // R2
  AST_R_PEEK_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (!r_en_n && r_wr_n && r_addr == MB_L && l_en_n) |=> $stable(l_irq_n)); // R3
  AST_HELD_WRITE_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (!l_en_n && !l_wr_n && l_addr == MB_R && l_hold && r_irq_n && r_en_n) |=> r_irq_n); // R4
  AST_HELD_READ_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!r_en_n && r_wr_n && r_addr == MB_R && r_hold && !r_irq_n) |=> !r_irq_n); // R5
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (l_en_n && r_en_n) |=> ($stable(l_irq_n) && $stable(r_irq_n) &&
                            l_rdata == '0 && r_rdata == '0)); // R8
endmodule

// File: tb/dmb_mailbox_top_tb_top.sv
`timescale 1ns/1ps
module dmb_mailbox_top_tb_top;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam logic [AW-1:0] MB_R = '1;
  localparam logic [AW-1:0] MB_L = MB_R - 1'b1;
  localparam int IDLE = 0, RD = 1, WR = 2, WR_OFF = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic l_en_n = 1'b1, l_wr_n = 1'b1, l_hold = 1'b0;
  logic r_en_n = 1'b1, r_wr_n = 1'b1, r_hold = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  always #4 clk = ~clk;

  dmb_mailbox_top #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst),
    .l_en_n(l_en_n), .l_wr_n(l_wr_n), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_hold(l_hold), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_en_n(r_en_n), .r_wr_n(r_wr_n), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_hold(r_hold), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  typedef struct {
    string         tag;
    logic          l_irq, r_irq;
    logic [DW-1:0] l_rd, r_rd;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // Requirement-level model: words and flags, index 0 = left, 1 = right.
  logic [DW-1:0] m_word [2] = '{16'h0, 16'h0};
  logic          m_flag [2] = '{1'b0, 1'b0};

  function automatic logic [AW-1:0] own_addr(int p);
    return (p == 1) ? MB_R : MB_L;
  endfunction

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag,
                      int lc, logic [AW-1:0] la, logic [DW-1:0] ld, logic lb,
                      int rc, logic [AW-1:0] ra, logic [DW-1:0] rd, logic rb);
    int c [2];
    logic [AW-1:0] a [2];
    logic [DW-1:0] d [2];
    logic b [2];
    logic [DW-1:0] rdv [2];
    logic setv [2], clrv [2], ownst [2];
    exp_t e;
    c[0] = lc; c[1] = rc; a[0] = la; a[1] = ra;
    d[0] = ld; d[1] = rd; b[0] = lb; b[1] = rb;
    @(negedge clk);
    l_en_n = !(lc == RD || lc == WR); l_wr_n = !(lc == WR || lc == WR_OFF);
    l_addr = la; l_wdata = ld; l_hold = lb;
    r_en_n = !(rc == RD || rc == WR); r_wr_n = !(rc == WR || rc == WR_OFF);
    r_addr = ra; r_wdata = rd; r_hold = rb;
    for (int p = 0; p < 2; p++) begin
      rdv[p] = '0;
      if (c[p] == RD && a[p] == own_addr(p))     rdv[p] = m_word[p];
      if (c[p] == RD && a[p] == own_addr(1 - p)) rdv[p] = m_word[1 - p];
    end
    for (int k = 0; k < 2; k++) begin
      setv[k]  = (c[1-k] == WR) && (a[1-k] == own_addr(k)) && !b[1-k];
      clrv[k]  = (c[k] == RD) && (a[k] == own_addr(k)) && !b[k];
      ownst[k] = (c[k] == WR) && (a[k] == own_addr(k)) && !b[k];
    end
    for (int k = 0; k < 2; k++) begin
      if (setv[k]) m_flag[k] = 1'b1;
      else if (clrv[k]) m_flag[k] = 1'b0;
      if (setv[k]) m_word[k] = d[1-k];
      else if (ownst[k]) m_word[k] = d[k];
    end
    e.tag = tag;
    e.l_irq = ~m_flag[0]; e.r_irq = ~m_flag[1];
    e.l_rd = rdv[0]; e.r_rd = rdv[1];
    q.push_back(e);
  endtask

  // Monitor: compares one expected item per cycle, 2 ns after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "l_irq_n", {15'b0, l_irq_n}, {15'b0, e.l_irq});
        check(e.tag, "r_irq_n", {15'b0, r_irq_n}, {15'b0, e.r_irq});
        check(e.tag, "l_rdata", l_rdata, e.l_rd);
        check(e.tag, "r_rdata", r_rdata, e.r_rd);
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset state
    check("R7", "l_irq_n", {15'b0, l_irq_n}, 16'h1);
    check("R7", "r_irq_n", {15'b0, r_irq_n}, 16'h1);
    check("R7", "l_rdata", l_rdata, 16'h0);
    check("R7", "r_rdata", r_rdata, 16'h0);
    rst = 1'b0;
    step("R7",  RD, MB_L, 0, 0,  RD, MB_R, 0, 0);
    step("R1",  WR, MB_R, 16'hA5A5, 0,  IDLE, 0, 0, 0);
    step("R3",  RD, MB_R, 0, 0,  IDLE, 0, 0, 0);
    step("R5",  IDLE, 0, 0, 0,  RD, MB_R, 0, 1);
    step("R2",  IDLE, 0, 0, 0,  RD, MB_R, 0, 0);
    step("R4",  IDLE, 0, 0, 0,  WR, MB_L, 16'h1234, 1);
    step("R4",  RD, MB_L, 0, 0,  IDLE, 0, 0, 0);
    step("R1",  IDLE, 0, 0, 0,  WR, MB_L, 16'h1234, 0);
    step("R3",  IDLE, 0, 0, 0,  RD, MB_L, 0, 0);
    step("R11", WR, MB_L, 16'hFFFF, 0,  IDLE, 0, 0, 0);
    step("R9",  RD, MB_L, 0, 0,  WR, MB_L, 16'h0F0F, 0);
    step("R6",  RD, MB_L, 0, 0,  IDLE, 0, 0, 0);
    step("R8",  WR_OFF, MB_R, 16'hDEAD, 0,  WR_OFF, MB_L, 16'hBEEF, 0);
    step("R8",  IDLE, 0, 0, 0,  RD, MB_R, 0, 0);
    step("R10", WR, MB_R, 16'h1111, 0,  WR, MB_R, 16'h2222, 0);
    step("R10", IDLE, 0, 0, 0,  RD, MB_R, 0, 0);
    step("R6",  RD, 10'h000, 0, 0,  RD, 10'h155, 0, 0);
    step("R6",  WR, MB_R, 16'h0000, 0,  WR, MB_L, 16'h8001, 0);
    step("R6",  RD, MB_R, 0, 0,  RD, MB_L, 0, 0);
    step("R2",  RD, MB_L, 0, 0,  RD, MB_R, 0, 0);
    step("R8",  IDLE, 0, 0, 0,  IDLE, 0, 0, 0);
    @(negedge clk);
    l_en_n = 1'b1; r_en_n = 1'b1;
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule